// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped table that the fetch stage consults with the current fetch PC. The PC is split into an index and a tag. The index selects one entry, and that entry's stored tag is compared with the tag bits of the PC. The lookup is purely combinational, so the predicted next fetch address is ready within the same cycle that the PC is presented.

Each entry holds four fields: a valid flag, a tag, a full-width target address and a 2-bit saturating direction counter. A tag match (a hit) sends fetch to the stored target only when the counter leans towards taken. Every other lookup yields the sequential address PC+4.

Branch resolution feeds a separate update port. A branch that hits trains the entry's counter. A taken branch that hits also refreshes the stored target. A taken branch that misses claims its entry. A not-taken branch that misses leaves the table unchanged.

Top module: `branch_target_buffer`

## Requirements
- R1: A synchronous active-high reset invalidates every entry, so every lookup after reset misses (hit=0, redirect=0, next PC = PC+4).
- R2: With the default depth of 16, the entry index is PC[5:2] and the tag is PC[31:6]. PC[1:0] plays no part in a lookup. A lookup hits only when the indexed entry is valid and its tag equals the tag of the PC.
- R3: On a miss, hit and redirect are 0 and the next PC is PC+4.
- R4: On a hit, hit is 1. If the counter's upper bit is 1, redirect is 1 and the next PC is the stored target. If the upper bit is 0, redirect is 0 and the next PC is PC+4.
- R5: A lookup is combinational in the cycle the PC is presented. An update takes effect at the clock edge that samples it, so a lookup of the same PC in that same cycle still sees the old contents.
- R6: A taken update that misses writes its entry with valid=1, the update tag, the update target and counter value 2'b10 (weakly taken). This replaces any entry with a different tag at that index.
- R7: A not-taken update that misses changes no entry.
- R8: An update that hits moves the counter up by one if taken and down by one if not taken. The counter encoding runs 00 (strongly not taken), 01, 10, 11 (strongly taken), and it saturates at 00 and 11.
- R9: A taken update that hits writes the update target into the entry.
- R10: The sequential next PC wraps modulo 2^32, so PC 0xFFFFFFFC gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Indexed entry is valid and its tag matches |
| lk_redirect | output | 1 | Fetch should go to the stored target |
| lk_next_pc | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | 30 | Word address (PC[31:2]) of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |
| up_target | input | 32 | Resolved target address |

## Verification
Lookup results are due in the same cycle as the PC, with no register in the path. The bench therefore drives lk_pc just after a falling edge and samples one nanosecond later, before the next rising edge. An update is committed at the first rising edge after it is driven, so its effect is checked on a lookup made after that edge. One scenario also presents the update and the lookup together and confirms a miss before the edge, which checks R5. The counter walks test saturation in both directions with sequences whose redirect pattern would differ if the counter wrapped instead of saturating.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_TAKEN = 2'b10;
    localparam ctr_t CTR_MAX        = 2'b11;
    localparam ctr_t CTR_MIN        = 2'b00;

    function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && cur != CTR_MAX)
            nxt = cur + ctr_t'(1);
        else if (!taken && cur != CTR_MIN)
            nxt = cur - ctr_t'(1);
        return nxt;
    endfunction

    function automatic logic ctr_predicts_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
    parameter int WORD_W = 30,
    parameter int IDX_W  = 4,
    localparam int TAG_W = WORD_W - IDX_W
) (
    input  logic [WORD_W-1:0] word_addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    assign idx = word_addr[IDX_W-1:0];
    assign tag = word_addr[WORD_W-1:IDX_W];
endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array
    import btb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 26,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    // fetch-side read
    input  logic [IDX_W-1:0]  ra_idx,
    output logic              ra_valid,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [ADDR_W-1:0] ra_tgt,
    output ctr_t              ra_ctr,
    // update-side read
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_valid,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [ADDR_W-1:0] rb_tgt,
    output ctr_t              rb_ctr,
    // write
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  ctr_t              wr_ctr
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] tgt;
        ctr_t              ctr;
    } entry_t;

    entry_t slots [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[e] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                slots[e].valid <= 1'b1;
                slots[e].tag   <= wr_tag;
                slots[e].tgt   <= wr_tgt;
                slots[e].ctr   <= wr_ctr;
            end
        end
    end

    always_comb begin
        ra_valid = slots[ra_idx].valid;
        ra_tag   = slots[ra_idx].tag;
        ra_tgt   = slots[ra_idx].tgt;
        ra_ctr   = slots[ra_idx].ctr;
        rb_valid = slots[rb_idx].valid;
        rb_tag   = slots[rb_idx].tag;
        rb_tgt   = slots[rb_idx].tgt;
        rb_ctr   = slots[rb_idx].ctr;
    end
endmodule

// File: rtl/btb_train.sv
module btb_train
    import btb_pkg::*;
#(
    parameter int TAG_W  = 26,
    parameter int ADDR_W = 32
) (
    input  logic              up_valid,
    input  logic              up_taken,
    input  logic [TAG_W-1:0]  up_tag,
    input  logic [ADDR_W-1:0] up_target,
    input  logic              cur_valid,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [ADDR_W-1:0] cur_tgt,
    input  ctr_t              cur_ctr,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [ADDR_W-1:0] wr_tgt,
    output ctr_t              wr_ctr
);
    logic match;

    assign match = cur_valid && (cur_tag == up_tag);

    always_comb begin
        wr_en  = 1'b0;
        wr_tag = up_tag;
        wr_tgt = up_target;
        wr_ctr = CTR_WEAK_TAKEN;
        if (up_valid) begin
            if (match) begin
                wr_en  = 1'b1;
                wr_tgt = up_taken ? up_target : cur_tgt;
                wr_ctr = ctr_train(cur_ctr, up_taken);
            end else if (up_taken) begin
                wr_en  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WORD_W = ADDR_W - 2,
    localparam int TAG_W  = WORD_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_redirect,
    output logic [ADDR_W-1:0] lk_next_pc,
    input  logic              up_valid,
    input  logic [ADDR_W-1:2] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic              ra_valid, rb_valid;
    logic [TAG_W-1:0]  ra_tag, rb_tag;
    logic [ADDR_W-1:0] ra_tgt, rb_tgt;
    ctr_t              ra_ctr, rb_ctr;
    logic              wr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic [ADDR_W-1:0] wr_tgt;
    ctr_t              wr_ctr;

    btb_pc_split #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_lk_split (
        .word_addr (lk_pc[ADDR_W-1:2]),
        .idx       (lk_idx),
        .tag       (lk_tag)
    );

    btb_pc_split #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_up_split (
        .word_addr (up_pc),
        .idx       (up_idx),
        .tag       (up_tag)
    );

    btb_entry_array #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .ra_idx   (lk_idx),
        .ra_valid (ra_valid),
        .ra_tag   (ra_tag),
        .ra_tgt   (ra_tgt),
        .ra_ctr   (ra_ctr),
        .rb_idx   (up_idx),
        .rb_valid (rb_valid),
        .rb_tag   (rb_tag),
        .rb_tgt   (rb_tgt),
        .rb_ctr   (rb_ctr),
        .wr_en    (wr_en),
        .wr_idx   (up_idx),
        .wr_tag   (wr_tag),
        .wr_tgt   (wr_tgt),
        .wr_ctr   (wr_ctr)
    );

    btb_train #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_train (
        .up_valid  (up_valid),
        .up_taken  (up_taken),
        .up_tag    (up_tag),
        .up_target (up_target),
        .cur_valid (rb_valid),
        .cur_tag   (rb_tag),
        .cur_tgt   (rb_tgt),
        .cur_ctr   (rb_ctr),
        .wr_en     (wr_en),
        .wr_tag    (wr_tag),
        .wr_tgt    (wr_tgt),
        .wr_ctr    (wr_ctr)
    );

    always_comb begin
        lk_hit      = ra_valid && (ra_tag == lk_tag);
        lk_redirect = lk_hit && ctr_predicts_taken(ra_ctr);
        lk_next_pc  = lk_redirect ? ra_tgt : lk_pc + ADDR_W'(4);
    end
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] lk_pc,
    input logic              lk_hit,
    input logic              lk_redirect,
    input logic [ADDR_W-1:0] lk_next_pc,
    input logic              up_valid,
    input logic [ADDR_W-1:2] up_pc,
    input logic              up_taken
);
    // R4
    redirect_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_redirect |-> lk_hit);

    // R3
    sequential_next_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_redirect |-> (lk_next_pc == lk_pc + ADDR_W'(4)));

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    // R6
    taken_present_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken) |=> (lk_pc[ADDR_W-1:2] != $past(up_pc) || lk_hit));
endmodule

bind branch_target_buffer btb_checker #(.ADDR_W(ADDR_W)) u_btb_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_pc       (lk_pc),
    .lk_hit      (lk_hit),
    .lk_redirect (lk_redirect),
    .lk_next_pc  (lk_next_pc),
    .up_valid    (up_valid),
    .up_pc       (up_pc),
    .up_taken    (up_taken)
);

// File: tb/tb_branch_target_buffer.sv
`timescale 1ns/1ps
module tb_branch_target_buffer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_pc = '0;
    logic        lk_hit, lk_redirect;
    logic [31:0] lk_next_pc;
    logic        up_valid = 1'b0;
    logic [31:2] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [31:0] up_target = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    branch_target_buffer dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_redirect(lk_redirect), .lk_next_pc(lk_next_pc),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_target(up_target)
    );

    localparam logic [31:0] PA = 32'h0000_1040; // index 0
    localparam logic [31:0] PB = 32'h0000_3080; // index 0, other tag
    localparam logic [31:0] PC = 32'h0000_1080; // index 0, other tag

    task automatic cmp(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // present a PC just after a falling edge, sample before the rising edge
    task automatic look(input string req, input logic [31:0] pc,
                        input logic eh, input logic er, input logic [31:0] en);
        @(negedge clk);
        lk_pc = pc;
        #1;
        cmp(req, "hit", {31'b0, lk_hit}, {31'b0, eh});
        cmp(req, "redirect", {31'b0, lk_redirect}, {31'b0, er});
        cmp(req, "next_pc", lk_next_pc, en);
    endtask

    task automatic resolve(input logic [31:0] pc, input logic taken, input logic [31:0] tgt);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc[31:2]; up_taken = taken; up_target = tgt;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        look("R1", 32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104);
        look("R1", PA, 1'b0, 1'b0, PA + 32'd4);
    endtask

    task automatic t_alloc();
        resolve(PA, 1'b1, 32'h0000_2000);
        look("R6", PA, 1'b1, 1'b1, 32'h0000_2000);
        look("R2", PA | 32'h3, 1'b1, 1'b1, 32'h0000_2000);
    endtask

    task automatic t_nt_miss();
        resolve(PB, 1'b0, 32'h0000_7000);
        look("R7", PB, 1'b0, 1'b0, PB + 32'd4);
        look("R7", PA, 1'b1, 1'b1, 32'h0000_2000);
    endtask

    task automatic t_counter();
        // PA counter starts at 10
        resolve(PA, 1'b0, 32'h0000_2000);               // 01
        look("R4", PA, 1'b1, 1'b0, PA + 32'd4);
        resolve(PA, 1'b0, 32'h0000_2000);               // 00
        resolve(PA, 1'b0, 32'h0000_2000);               // 00 saturated
        resolve(PA, 1'b1, 32'h0000_2000);               // 01
        look("R8", PA, 1'b1, 1'b0, PA + 32'd4);
        resolve(PA, 1'b1, 32'h0000_2000);               // 10
        look("R8", PA, 1'b1, 1'b1, 32'h0000_2000);
        resolve(PA, 1'b1, 32'h0000_2000);               // 11
        resolve(PA, 1'b1, 32'h0000_2000);               // 11 saturated
        resolve(PA, 1'b0, 32'h0000_2000);               // 10
        look("R8", PA, 1'b1, 1'b1, 32'h0000_2000);
        resolve(PA, 1'b0, 32'h0000_2000);               // 01
        look("R8", PA, 1'b1, 1'b0, PA + 32'd4);
    endtask

    task automatic t_target();
        resolve(PA, 1'b1, 32'h0000_3000);               // 10, new target
        look("R9", PA, 1'b1, 1'b1, 32'h0000_3000);
    endtask

    task automatic t_conflict();
        look("R2", PC, 1'b0, 1'b0, PC + 32'd4);
        resolve(PC, 1'b1, 32'h0000_5000);
        look("R6", PC, 1'b1, 1'b1, 32'h0000_5000);
        look("R6", PA, 1'b0, 1'b0, PA + 32'd4);
    endtask

    task automatic t_index();
        resolve(32'h0000_0008, 1'b1, 32'h0000_0800);
        look("R2", 32'h0000_0004, 1'b0, 1'b0, 32'h0000_0008);
        look("R2", 32'h0000_0008, 1'b1, 1'b1, 32'h0000_0800);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        up_valid = 1'b1; up_pc = 30'h0000_0804; up_taken = 1'b1; up_target = 32'h0000_9000;
        lk_pc = 32'h0000_2010;
        #1;
        cmp("R5", "hit before edge", {31'b0, lk_hit}, 32'd0);
        cmp("R5", "next_pc before edge", lk_next_pc, 32'h0000_2014);
        @(negedge clk);
        up_valid = 1'b0;
        #1;
        cmp("R5", "next_pc after edge", lk_next_pc, 32'h0000_9000);
    endtask

    task automatic t_wrap();
        look("R10", 32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0000_0000);
    endtask

    task automatic t_reset_again();
        do_reset();
        look("R1", PC, 1'b0, 1'b0, PC + 32'd4);
        look("R1", 32'h0000_2010, 1'b0, 1'b0, 32'h0000_2014);
    endtask

    initial begin
        t_reset();
        t_alloc();
        t_nt_miss();
        t_counter();
        t_target();
        t_conflict();
        t_index();
        t_same_cycle();
        t_wrap();
        t_reset_again();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule